// File: doc/BRIEF.md
# Parallel Pseudo-Random Bit Sequence Generator

This block is a linear feedback shift register that advances by N serial steps on every enabled clock edge. In one clock it delivers the N bits that a one-bit-per-clock generator would have shifted out over N clocks. A slow logic clock can therefore feed a fast external parallel-to-serial converter. The register length L, the tap mask, the feedback polarity (XOR or XNOR) and the step count N are parameters. The next-state logic is the single-step update applied N times in a row, so the block uses no more flip-flops than the one-bit generator.

A seed port loads the state directly. The block watches for the one state the feedback can never leave: all zeros with XOR feedback, all ones with XNOR feedback. When the state is that value, whether it came from a load or from reset, the block replaces it with a fixed recovery value on the next clock edge.

Top module: `prbs_par_gen`

## Requirements
- R1: The state register is exactly L flip-flops wide and is visible on `state_o`. Bit i of `state_o` is stage i+1 of the shift chain.
- R2: One serial step is defined as follows. Stage 1 takes the parity of the stages selected by `TAP_MASK` (bit i selects stage i+1), inverted when `XNOR_FB` is 1. Every other stage k takes the old value of stage k-1. After each edge that has `en_i` high, `load_i` low and no lockup, the state equals N serial steps applied to the old state.
- R3: `word_o` holds the N serial output bits produced by the last advance, with `word_o[N-1]` sent first. Serial bit k is stage L before step k. For L=4 and N=2 this gives `word_o[1]`=Q4 and `word_o[0]`=Q3 of the old state.
- R4: While `en_i` is low, the state (when it is not lockup and no load is pending) and `word_o` keep their values.
- R5: When `load_i` is high, the next edge writes `seed_i` into the state. A load takes priority over both enable and lockup recovery, and it leaves `word_o` unchanged.
- R6: If the state is the lockup value (all zeros for XOR, all ones for XNOR) and `load_i` is low, the next edge writes `RECOVER_SEED` into the state, whatever `en_i` is.
- R7: `valid_o` is high for the cycle after an edge that advanced the state, and low after every other edge.
- R8: `rst_ni` low sets the state to `RESET_SEED`, `word_o` to 0 and `valid_o` to 0.
- R9: With the default parameters (L=4, taps Q3 and Q4, XOR, N=2) the generator runs from 1111 through the states Q1..Q4 = 0011, 1000, 0010, 1100, 1011, 1010, 1110, 0111. On `state_o` these are 4'hC, 1, 4, 3, D, 5, 7, E. The state returns to 4'hF after 15 advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance by N serial steps |
| load_i | input | 1 | Load seed_i into the state |
| seed_i | input | L | Seed value |
| word_o | output | N | Parallel output word, bit N-1 sent first |
| valid_o | output | 1 | word_o was refreshed by the last edge |
| state_o | output | L | Current register state |

## Verification
Every result is due exactly one rising edge after the inputs that cause it. The new state, the new output word and `valid_o` all appear after that same edge, and a recovery from lockup also takes exactly one edge. The bench changes inputs on the falling edge and samples on the next falling edge. Before each rising edge it updates a serial reference model, which takes N single steps per clock. After the edge it compares the state, the word and `valid_o` against that model on every cycle. Two instances run side by side: the default XOR generator, and a 7-stage XNOR generator with N larger than L.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_STEP,
    ACT_LOAD,
    ACT_RECOVER
  } prbs_act_e;
endpackage

// File: rtl/prbs_unroll.sv
module prbs_unroll #(
  parameter int unsigned   L        = 4,
  parameter int unsigned   N        = 2,
  parameter logic [L-1:0]  TAP_MASK = 4'b1100,
  parameter bit            XNOR_FB  = 1'b0
) (
  input  logic [L-1:0] cur_i,
  output logic [L-1:0] nxt_o,
  output logic [N-1:0] word_o
);
  logic [L-1:0] s_w;

  // serial update composed N times; bit emitted at step k is stage L before step k
  always_comb begin
    s_w    = cur_i;
    word_o = '0;
    for (int k = 0; k < N; k++) begin
      word_o[N-1-k] = s_w[L-1];
      s_w = {s_w[L-2:0], (^(s_w & TAP_MASK)) ^ XNOR_FB};
    end
    nxt_o = s_w;
  end
endmodule

// File: rtl/prbs_lock_det.sv
module prbs_lock_det #(
  parameter int unsigned L       = 4,
  parameter bit          XNOR_FB = 1'b0
) (
  input  logic [L-1:0] st_i,
  output logic         lock_o
);
  if (XNOR_FB) begin : g_xnor
    assign lock_o = &st_i;
  end else begin : g_xor
    assign lock_o = ~|st_i;
  end
endmodule

// File: rtl/prbs_ctrl.sv
module prbs_ctrl
  import prbs_pkg::*;
(
  input  logic      en_i,
  input  logic      load_i,
  input  logic      lock_i,
  output prbs_act_e act_o
);
  always_comb begin
    if (load_i)      act_o = ACT_LOAD;
    else if (lock_i) act_o = ACT_RECOVER;
    else if (en_i)   act_o = ACT_STEP;
    else             act_o = ACT_HOLD;
  end
endmodule

// File: rtl/prbs_par_gen.sv
module prbs_par_gen
  import prbs_pkg::*;
#(
  parameter int unsigned  L            = 4,
  parameter int unsigned  N            = 2,
  parameter logic [L-1:0] TAP_MASK     = 4'b1100,
  parameter bit           XNOR_FB      = 1'b0,
  parameter logic [L-1:0] RESET_SEED   = 4'hF,
  parameter logic [L-1:0] RECOVER_SEED = 4'h1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [L-1:0] seed_i,
  output logic [N-1:0] word_o,
  output logic         valid_o,
  output logic [L-1:0] state_o
);
  logic [L-1:0] state_q, nxt_w;
  logic [N-1:0] word_q, word_nxt_w;
  logic         valid_q, lock_w;
  prbs_act_e    act_w;

  prbs_unroll #(.L(L), .N(N), .TAP_MASK(TAP_MASK), .XNOR_FB(XNOR_FB)) u_unroll (
    .cur_i (state_q),
    .nxt_o (nxt_w),
    .word_o(word_nxt_w)
  );

  prbs_lock_det #(.L(L), .XNOR_FB(XNOR_FB)) u_lock (
    .st_i  (state_q),
    .lock_o(lock_w)
  );

  prbs_ctrl u_ctrl (
    .en_i  (en_i),
    .load_i(load_i),
    .lock_i(lock_w),
    .act_o (act_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RESET_SEED;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= (act_w == ACT_STEP);
      unique case (act_w)
        ACT_LOAD:    state_q <= seed_i;
        ACT_RECOVER: state_q <= RECOVER_SEED;
        ACT_STEP: begin
          state_q <= nxt_w;
          word_q  <= word_nxt_w;
        end
        default: ;
      endcase
    end
  end

  assign state_o = state_q;
  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/prbs_par_gen_chk.sv
module prbs_par_gen_chk #(
  parameter int unsigned  L            = 4,
  parameter int unsigned  N            = 2,
  parameter bit           XNOR_FB      = 1'b0,
  parameter logic [L-1:0] RECOVER_SEED = 4'h1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         load_i,
  input logic [L-1:0] seed_i,
  input logic [N-1:0] word_o,
  input logic         valid_o,
  input logic [L-1:0] state_o
);
  localparam logic [L-1:0] LOCK_VAL = XNOR_FB ? {L{1'b1}} : {L{1'b0}};

  a_r4_state_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i && state_o != LOCK_VAL) |=> $stable(state_o));

  a_r4_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(word_o));

  a_r5_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> state_o == $past(seed_i));

  a_r6_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == LOCK_VAL && !load_i) |=> state_o == RECOVER_SEED);

  a_r7_valid_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(en_i && !load_i));

  a_r7_no_valid_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !valid_o);
endmodule

bind prbs_par_gen prbs_par_gen_chk #(
  .L(L), .N(N), .XNOR_FB(XNOR_FB), .RECOVER_SEED(RECOVER_SEED)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .load_i (load_i),
  .seed_i (seed_i),
  .word_o (word_o),
  .valid_o(valid_o),
  .state_o(state_o)
);

// File: tb/prbs_par_gen_tb.sv
module prbs_par_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic load = 1'b0;
  logic [3:0] seed_a = '0;
  logic [6:0] seed_b = '0;
  logic [1:0] word_a;
  logic [8:0] word_b;
  logic [3:0] state_a;
  logic [6:0] state_b;
  logic valid_a, valid_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] ms_a, mw_a, ms_b, mw_b;
  logic mv_a, mv_b;

  always #4 clk = ~clk;

  prbs_par_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .load_i(load), .seed_i(seed_a),
    .word_o(word_a), .valid_o(valid_a), .state_o(state_a)
  );

  prbs_par_gen #(
    .L(7), .N(9), .TAP_MASK(7'b1100000), .XNOR_FB(1'b1),
    .RESET_SEED(7'h7F), .RECOVER_SEED(7'h01)
  ) u_dut_w (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .load_i(load), .seed_i(seed_b),
    .word_o(word_b), .valid_o(valid_b), .state_o(state_b)
  );

  function automatic logic [15:0] m_step(input logic [15:0] s, input int l,
                                         input logic [15:0] taps, input bit xn);
    logic fb;
    logic [15:0] r;
    fb = (^(s & taps)) ^ xn;
    r = (s << 1) | {15'd0, fb};
    return r & ((16'd1 << l) - 16'd1);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_edge(inout logic [15:0] ms, inout logic [15:0] mw, output logic mv,
                            input logic [15:0] sd, input int l, input int n,
                            input logic [15:0] taps, input bit xn, input logic [15:0] rec);
    logic [15:0] lockv;
    lockv = xn ? ((16'd1 << l) - 16'd1) : 16'd0;
    mv = 1'b0;
    if (load) ms = sd;
    else if (ms == lockv) ms = rec;
    else if (en) begin
      for (int k = 0; k < n; k++) begin
        mw[n-1-k] = ms[l-1];
        ms = m_step(ms, l, taps, xn);
      end
      mv = 1'b1;
    end
  endtask

  // one edge: update model, clock, sample on falling edge, compare
  task automatic tick(input string tag);
    model_edge(ms_a, mw_a, mv_a, {12'd0, seed_a}, 4, 2, 16'h000C, 1'b0, 16'h0001);
    model_edge(ms_b, mw_b, mv_b, {9'd0, seed_b}, 7, 9, 16'h0060, 1'b1, 16'h0001);
    @(posedge clk);
    @(negedge clk);
    check({tag, " state_a"}, {12'd0, state_a}, ms_a);
    check({tag, " word_a"}, {14'd0, word_a}, mw_a);
    check({tag, " valid_a"}, {15'd0, valid_a}, {15'd0, mv_a});
    check({tag, " state_b"}, {9'd0, state_b}, ms_b);
    check({tag, " word_b"}, {7'd0, word_b}, mw_b);
    check({tag, " valid_b"}, {15'd0, valid_b}, {15'd0, mv_b});
  endtask

  task automatic t_reset_r8;
    rst_n = 1'b0;
    #20;
    @(negedge clk);
    check("R8 reset state_a", {12'd0, state_a}, 16'h000F);
    check("R8 reset word_a", {14'd0, word_a}, 16'h0000);
    check("R8 reset valid_a", {15'd0, valid_a}, 16'h0000);
    check("R8 reset state_b", {9'd0, state_b}, 16'h007F);
    check("R1 state width", 16'($bits(state_a)), 16'd4);
    ms_a = 16'h000F; mw_a = '0; mv_a = 1'b0;
    ms_b = 16'h007F; mw_b = '0; mv_b = 1'b0;
    rst_n = 1'b1;
    // reset value of the XNOR instance is lockup: recovered on first edge
    tick("R6 recover after reset");
    check("R6 state_b recovered", {9'd0, state_b}, 16'h0001);
  endtask

  task automatic t_seq_r9;
    logic [3:0] exp_seq [8] = '{4'hC, 4'h1, 4'h4, 4'h3, 4'hD, 4'h5, 4'h7, 4'hE};
    en = 1'b1;
    tick("R9 first advance");
    check("R9 seq", {12'd0, state_a}, {12'd0, exp_seq[0]});
    check("R3 first word Q4,Q3", {14'd0, word_a}, 16'h0003);
    for (int i = 1; i < 8; i++) begin
      tick("R2 seq");
      check("R9 seq", {12'd0, state_a}, {12'd0, exp_seq[i]});
    end
    for (int i = 8; i < 15; i++) tick("R2 seq");
    check("R9 period 15", {12'd0, state_a}, 16'h000F);
  endtask

  task automatic t_hold_r4;
    en = 1'b0;
    for (int i = 0; i < 3; i++) tick("R4 hold");
    check("R7 valid low when idle", {15'd0, valid_a}, 16'h0000);
    en = 1'b1;
    tick("R7 resume");
    check("R7 valid after advance", {15'd0, valid_a}, 16'h0001);
  endtask

  task automatic t_load_r5;
    en = 1'b1; load = 1'b1; seed_a = 4'hA; seed_b = 7'h35;
    tick("R5 load");
    check("R5 loaded a", {12'd0, state_a}, 16'h000A);
    check("R5 loaded b", {9'd0, state_b}, 16'h0035);
    check("R5 no valid on load", {15'd0, valid_a}, 16'h0000);
    load = 1'b0;
    tick("R2 after load");
  endtask

  task automatic t_lock_r6;
    en = 1'b1; load = 1'b1; seed_a = 4'h0; seed_b = 7'h7F;
    tick("R6 load lockup");
    check("R6 lockup held a", {12'd0, state_a}, 16'h0000);
    load = 1'b0; en = 1'b0;
    tick("R6 recover");
    check("R6 recovered a", {12'd0, state_a}, 16'h0001);
    check("R6 recovered b", {9'd0, state_b}, 16'h0001);
    en = 1'b1;
    tick("R2 after recover");
  endtask

  task automatic t_mixed_r2;
    for (int i = 0; i < 300; i++) begin
      en = ((i * 7) % 5) != 0;
      load = (i % 37) == 20;
      seed_a = 4'(i * 3);
      seed_b = 7'(i * 11);
      tick("R2 mixed");
    end
    load = 1'b0;
  endtask

  initial begin
    t_reset_r8();
    t_seq_r9();
    t_hold_r4();
    t_load_r5();
    t_lock_r6();
    t_mixed_r2();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule